// File: doc/BRIEF.md
# Byte-Lane Asynchronous Memory Controller with Supply Lockout

This block is a synchronous controller that sits on the host side of an asynchronous, SRAM-style, 16-bit non-volatile memory with 1M words. A host issues requests over a valid/ready handshake. Each request carries a 20-bit word address, 16 bits of write data, two active-high byte enables and a read/write select. The controller turns each request into one timed access on the memory's active-low chip-enable, write-enable, output-enable and upper/lower byte-enable strobes. It drives the write data on byte lanes, each with its own output enable, and returns read data as a one-cycle response pulse.

The minimum access time is given in picoseconds and converted to a clock count. Every access holds chip enable low for that many cycles. When the supply-good input rises, a startup timer keeps every strobe inactive and the handshake closed for a set number of cycles. A brownout clears supply-good, which cuts any access at once and restarts the full timer. While the supply-low input is set, no write strobe is issued. Reads still proceed.

Top module: `mctl_top`

## Requirements
- R1: After reset, and while the startup timer runs, req_ready_o is 0 and mem_ce_no, mem_we_no and mem_oe_no are 1. req_ready_o first reads 1 exactly STARTUP_CYC clock edges after pwr_good_i is first sampled high.
- R2: When pwr_good_i is low, req_ready_o is 0 in the same cycle and all strobes are inactive from the next edge. An access in flight ends with rsp_valid_o=1 and rsp_err_o=1 one cycle later. When pwr_good_i returns, the full STARTUP_CYC wait applies again.
- R3: Every completed access holds mem_ce_no low for exactly ACC_CYC = ceil(ACCESS_PS / CLK_PERIOD_PS) cycles (9 by default). rsp_valid_o pulses in the cycle after mem_ce_no rises.
- R4: A read drives mem_ce_no=0, mem_we_no=1 and mem_oe_no=0 for the whole access. mem_ub_no is low iff req_be_i[1] is set, and mem_lb_no is low iff req_be_i[0] is set. mem_dq_i is sampled on the last access cycle. On rsp_rdata_o, lanes that were not enabled read 0.
- R5: On a write, mem_oe_no stays 1 and mem_we_no is low only in access cycles 1 to ACC_CYC-2. The selected data lanes are driven in every cycle from 0 to ACC_CYC-1, which gives one cycle of margin before write enable falls and one after it rises.
- R6: mem_dq_oe_o[1] drives bits [15:8] and is set only on writes with req_be_i[1] set. mem_dq_oe_o[0] drives bits [7:0] with req_be_i[0]. Reads never drive the lanes.
- R7: While pwr_low_i is 1, mem_we_no stays 1. A write accepted while pwr_low_i is 1 issues no strobe and responds one cycle later with rsp_err_o=1, leaving memory unchanged. Reads are unaffected.
- R8: A request with req_be_i=2'b00 produces no strobe. It responds one cycle after acceptance with rsp_err_o=0 and rsp_rdata_o=0.
- R9: req_ready_o is 1 only when no access is in flight and the lockout is over. A write response returns rsp_rdata_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_good_i | input | 1 | Supply within range |
| pwr_low_i | input | 1 | Supply below write-inhibit level |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, [1] upper, [0] lower |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_err_o | output | 1 | Access aborted or inhibited |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| mem_addr_o | output | 20 | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_ub_no | output | 1 | Upper byte enable, active low |
| mem_lb_no | output | 1 | Lower byte enable, active low |
| mem_dq_o | output | 16 | Write data lanes |
| mem_dq_oe_o | output | 2 | Per-lane drive enable, [1] upper |
| mem_dq_i | input | 16 | Read data lanes |

## Verification
Inputs change on falling edges, and outputs are sampled on falling edges that are counted from the one where the stimulus was applied. An accepted access shows mem_ce_no low on falling edges 1 to ACC_CYC, and its response is due on edge ACC_CYC+1. A no-op or an inhibited write responds on edge 1. After pwr_good_i rises, req_ready_o must stay low up to edge STARTUP_CYC-1 and be high on edge STARTUP_CYC. A supply drop must show idle strobes and an error response on the very next falling edge. Each scenario task checks the exact edge, not a window, and a per-cycle monitor counts any lane drive that lacks margin around write enable or that does not match the byte enables.

// File: rtl/mctl_pkg.sv
package mctl_pkg;
  typedef enum logic {ST_IDLE, ST_ACT} mctl_state_e;

  typedef struct packed {
    logic       ce_n;
    logic       we_n;
    logic       oe_n;
    logic       ub_n;
    logic       lb_n;
    logic [1:0] dq_oe;
  } strobe_t;

  localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                      ub_n: 1'b1, lb_n: 1'b1, dq_oe: 2'b00};
endpackage

// File: rtl/mctl_lockout.sv
module mctl_lockout #(
  parameter int STARTUP_CYC = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  output logic open_o
);
  localparam int CW = $clog2(STARTUP_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(STARTUP_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!pwr_good_i) cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign open_o = pwr_good_i && (cnt_q == LIM);
endmodule

// File: rtl/mctl_lanes.sv
module mctl_lanes #(
  parameter int DW = 16
) (
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] raw_i,
  output logic          ub_no,
  output logic          lb_no,
  output logic [1:0]    dq_oe_o,
  output logic [DW-1:0] masked_o
);
  localparam int LW = DW / 2;
  logic [1:0] sel_n;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign sel_n[i]            = !(en_i && be_i[i]);
    assign dq_oe_o[i]          = en_i && wr_i && be_i[i];
    assign masked_o[i*LW +: LW] = be_i[i] ? raw_i[i*LW +: LW] : '0;
  end

  assign ub_no = sel_n[1];
  assign lb_no = sel_n[0];
endmodule

// File: rtl/mctl_top.sv
module mctl_top
  import mctl_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACCESS_PS     = 35000,
  parameter int STARTUP_CYC   = 500000,
  parameter int AW            = 20,
  parameter int DW            = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_good_i,
  input  logic          pwr_low_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  input  logic [1:0]    req_be_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_we_no,
  output logic          mem_oe_no,
  output logic          mem_ub_no,
  output logic          mem_lb_no,
  output logic [DW-1:0] mem_dq_o,
  output logic [1:0]    mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int ACC_RAW = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACC_CYC = (ACC_RAW < 3) ? 3 : ACC_RAW;
  localparam int CNT_W   = $clog2(ACC_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_CYC - 1);

  mctl_state_e   state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic          wr_q, load, fin, open;
  logic [1:0]    be_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, rd_masked;
  logic          rsp_v_q, rsp_e_q, rsp_v_d, rsp_e_d;
  strobe_t       strb_q, strb_d;
  logic          act_wr, act_en;
  logic [1:0]    act_be;

  mctl_lockout #(.STARTUP_CYC(STARTUP_CYC)) u_lock (
    .clk_i, .rst_ni, .pwr_good_i, .open_o(open)
  );

  assign req_ready_o = open && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    fin     = 1'b0;
    rsp_v_d = 1'b0;
    rsp_e_d = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i && req_ready_o) begin
        if (req_be_i == 2'b00) begin
          rsp_v_d = 1'b1;
        end else if (req_we_i && pwr_low_i) begin
          rsp_v_d = 1'b1;
          rsp_e_d = 1'b1;
        end else begin
          state_d = ST_ACT;
          cnt_d   = '0;
          load    = 1'b1;
        end
      end
      ST_ACT: begin
        if (!pwr_good_i || (wr_q && pwr_low_i)) begin
          state_d = ST_IDLE;
          rsp_v_d = 1'b1;
          rsp_e_d = 1'b1;
        end else if (cnt_q == LAST) begin
          state_d = ST_IDLE;
          rsp_v_d = 1'b1;
          fin     = !wr_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign act_wr = load ? req_we_i : wr_q;
  assign act_be = load ? req_be_i : be_q;
  assign act_en = (state_d == ST_ACT);

  mctl_lanes #(.DW(DW)) u_lanes (
    .en_i(act_en), .wr_i(act_wr), .be_i(act_be), .raw_i(mem_dq_i),
    .ub_no(strb_d.ub_n), .lb_no(strb_d.lb_n), .dq_oe_o(strb_d.dq_oe),
    .masked_o(rd_masked)
  );

  // write strobe sits one cycle inside the lane-drive window on each side
  assign strb_d.ce_n = !act_en;
  assign strb_d.oe_n = !(act_en && !act_wr);
  assign strb_d.we_n = !(act_en && act_wr && (cnt_d != '0) && (cnt_d != LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      be_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_v_q <= 1'b0;
      rsp_e_q <= 1'b0;
      strb_q  <= STROBE_IDLE;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rsp_v_q <= rsp_v_d;
      rsp_e_q <= rsp_e_d;
      strb_q  <= strb_d;
      if (load) begin
        wr_q    <= req_we_i;
        be_q    <= req_be_i;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (fin)          rdata_q <= rd_masked;
      else if (rsp_v_d) rdata_q <= '0;
    end
  end

  assign rsp_valid_o = rsp_v_q;
  assign rsp_err_o   = rsp_e_q;
  assign rsp_rdata_o = rdata_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_ce_no   = strb_q.ce_n;
  assign mem_we_no   = strb_q.we_n;
  assign mem_oe_no   = strb_q.oe_n;
  assign mem_ub_no   = strb_q.ub_n;
  assign mem_lb_no   = strb_q.lb_n;
  assign mem_dq_oe_o = strb_q.dq_oe;
endmodule

// File: rtl/mctl_chk.sv
module mctl_chk #(
  parameter int CLK_PERIOD_PS = 4000,
  parameter int ACCESS_PS     = 35000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_good_i,
  input logic       pwr_low_i,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_be_i,
  input logic       rsp_valid_o,
  input logic       rsp_err_o,
  input logic       mem_ce_no,
  input logic       mem_we_no,
  input logic       mem_oe_no,
  input logic       mem_ub_no,
  input logic       mem_lb_no,
  input logic [1:0] mem_dq_oe_o
);
  localparam int ACC_RAW = (ACCESS_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int ACC_CYC = (ACC_RAW < 3) ? 3 : ACC_RAW;

  logic [15:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (mem_ce_no)  run_q <= '0;
    else if (run_q != '1) run_q <= run_q + 1'b1;
  end

  assert_drop_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |=> (mem_ce_no && mem_we_no && mem_oe_no));
  assert_drop_closed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> !req_ready_o);
  assert_access_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_ce_no) && rsp_valid_o && !rsp_err_o) |-> (run_q == 16'(ACC_CYC)));
  assert_read_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> (!mem_ce_no && mem_we_no && mem_dq_oe_o == 2'b00));
  assert_we_setup_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_no) |-> ($past(mem_dq_oe_o) != 2'b00));
  assert_we_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(mem_we_no) && !mem_ce_no) |-> (mem_dq_oe_o != 2'b00));
  assert_upper_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o[1] |-> (!mem_ub_no && !mem_ce_no));
  assert_lower_lane_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o[0] |-> (!mem_lb_no && !mem_ce_no));
  assert_inhibit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_low_i |=> mem_we_no);
  assert_noop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_be_i == 2'b00) |=>
      (rsp_valid_o && !rsp_err_o && mem_ce_no));
  assert_ready_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_ce_no |-> !req_ready_o);
endmodule

bind mctl_top mctl_chk #(.CLK_PERIOD_PS(CLK_PERIOD_PS), .ACCESS_PS(ACCESS_PS)) u_chk (.*);

// File: tb/sim_mctl_top.sv
module sim_mctl_top;
  localparam int STARTUP = 20;
  localparam int ACC     = (35000 + 4000 - 1) / 4000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pg = 1'b0, plow = 1'b0;
  logic rv = 1'b0, rdy, rwe = 1'b0;
  logic [19:0] raddr = '0;
  logic [15:0] rwd = '0;
  logic [1:0]  rbe = '0;
  logic rspv, rspe;
  logic [15:0] rrd, mdq, mdi;
  logic [19:0] maddr;
  logic ce_n, we_n, oe_n, ub_n, lb_n;
  logic [1:0] dqoe;

  int total = 0, bad = 0;
  int lane_bad = 0, margin_bad = 0, we_cycles = 0;
  logic [15:0] mem [16];
  logic [1:0] dqoe_prev = 2'b00;
  logic we_prev = 1'b1;

  always #2 clk = ~clk;

  mctl_top #(.CLK_PERIOD_PS(4000), .ACCESS_PS(35000), .STARTUP_CYC(STARTUP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_good_i(pg), .pwr_low_i(plow),
    .req_valid_i(rv), .req_ready_o(rdy), .req_we_i(rwe), .req_addr_i(raddr),
    .req_wdata_i(rwd), .req_be_i(rbe), .rsp_valid_o(rspv), .rsp_err_o(rspe),
    .rsp_rdata_o(rrd), .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_ub_no(ub_n), .mem_lb_no(lb_n), .mem_dq_o(mdq),
    .mem_dq_oe_o(dqoe), .mem_dq_i(mdi)
  );

  // memory model: unselected lanes return junk that must be masked
  assign mdi = (!ce_n && !oe_n) ?
               {ub_n ? 8'hEE : mem[maddr[3:0]][15:8], lb_n ? 8'hEE : mem[maddr[3:0]][7:0]}
               : 16'hBAD0;

  always @(negedge clk) begin
    if (rst_n) begin
      if ((dqoe[1] && ub_n) || (dqoe[0] && lb_n) || (dqoe != 2'b00 && !oe_n)) lane_bad++;
      if (we_prev && !we_n && dqoe_prev == 2'b00) margin_bad++;
      if (!we_prev && we_n && !ce_n && dqoe == 2'b00) margin_bad++;
      if (!we_n) we_cycles++;
      if (!we_n && !ce_n) begin
        if (dqoe[1] && !ub_n) mem[maddr[3:0]][15:8] = mdq[15:8];
        if (dqoe[0] && !lb_n) mem[maddr[3:0]][7:0]  = mdq[7:0];
      end
    end
    dqoe_prev <= dqoe;
    we_prev   <= we_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drives one request; returns response data, flag, latency and ce-low count
  task automatic access(input bit we, input logic [19:0] a, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd,
                        output bit err, output int lat, output int ce_cnt);
    @(negedge clk);
    rv = 1'b1; rwe = we; raddr = a; rbe = be; rwd = wd;
    lat = 0; ce_cnt = 0; rd = '0; err = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (k == 1) rv = 1'b0;
      if (!ce_n) ce_cnt++;
      if (rspv) begin
        lat = k; rd = rrd; err = rspe;
        break;
      end
    end
  endtask

  task automatic t_reset;
    chk(rdy == 1'b0, "R1", "ready in reset", rdy, 0);
    chk({ce_n, we_n, oe_n} == 3'b111, "R1", "strobes in reset", {ce_n, we_n, oe_n}, 3'b111);
    chk(rspv == 1'b0, "R9", "rsp in reset", rspv, 0);
  endtask

  task automatic t_startup;
    int early = 0, strobe = 0;
    @(negedge clk);
    pg = 1'b1;
    rv = 1'b1; rbe = 2'b11;
    for (int k = 1; k < STARTUP; k++) begin
      @(negedge clk);
      if (rdy) early++;
      if (!ce_n || !we_n) strobe++;
    end
    rv = 1'b0;
    chk(early == 0, "R1", "ready during startup", early, 0);
    chk(strobe == 0, "R1", "strobes during startup", strobe, 0);
    @(negedge clk);
    chk(rdy == 1'b1, "R1", "ready at startup end", rdy, 1);
  endtask

  task automatic t_word;
    logic [15:0] rd; bit err; int lat, cc;
    access(1'b1, 20'h00005, 2'b11, 16'hA5A5, rd, err, lat, cc);
    chk(lat == ACC + 1, "R3", "write latency", lat, ACC + 1);
    chk(cc == ACC, "R3", "write ce cycles", cc, ACC);
    chk(rd == 16'h0 && !err, "R9", "write rsp data", rd, 0);
    chk(mem[5] == 16'hA5A5, "R5", "word written", mem[5], 16'hA5A5);
    access(1'b0, 20'h00005, 2'b11, 16'h0, rd, err, lat, cc);
    chk(rd == 16'hA5A5, "R4", "word read", rd, 16'hA5A5);
    chk(cc == ACC && lat == ACC + 1, "R3", "read ce cycles", cc, ACC);
  endtask

  task automatic t_bytes;
    logic [15:0] rd; bit err; int lat, cc, w0;
    access(1'b1, 20'h00002, 2'b11, 16'h1111, rd, err, lat, cc);
    w0 = we_cycles;
    access(1'b1, 20'h00002, 2'b01, 16'h22CC, rd, err, lat, cc);
    chk(we_cycles - w0 == ACC - 2, "R5", "we low cycles", we_cycles - w0, ACC - 2);
    access(1'b0, 20'h00002, 2'b11, 16'h0, rd, err, lat, cc);
    chk(rd == 16'h11CC, "R6", "lower write kept upper", rd, 16'h11CC);
    access(1'b0, 20'h00002, 2'b10, 16'h0, rd, err, lat, cc);
    chk(rd == 16'h1100, "R4", "upper read mask", rd, 16'h1100);
    access(1'b0, 20'h00002, 2'b01, 16'h0, rd, err, lat, cc);
    chk(rd == 16'h00CC, "R4", "lower read mask", rd, 16'h00CC);
    access(1'b1, 20'h00002, 2'b10, 16'hAB00, rd, err, lat, cc);
    chk(mem[2] == 16'hABCC, "R6", "upper write", mem[2], 16'hABCC);
    chk(lane_bad == 0, "R6", "lane drive mismatch", lane_bad, 0);
    chk(margin_bad == 0, "R5", "lane margin", margin_bad, 0);
  endtask

  task automatic t_noop;
    logic [15:0] rd; bit err; int lat, cc;
    access(1'b1, 20'h00005, 2'b00, 16'hFFFF, rd, err, lat, cc);
    chk(lat == 1 && cc == 0 && !err, "R8", "noop rsp", lat, 1);
    chk(mem[5] == 16'hA5A5, "R8", "noop memory", mem[5], 16'hA5A5);
  endtask

  task automatic t_inhibit;
    logic [15:0] rd; bit err; int lat, cc, w0;
    plow = 1'b1;
    w0 = we_cycles;
    access(1'b1, 20'h00005, 2'b11, 16'h1234, rd, err, lat, cc);
    chk(lat == 1 && err && cc == 0, "R7", "inhibited write rsp", {lat[7:0], 7'b0, err}, 16'h0101);
    chk(we_cycles == w0, "R7", "no we strobe", we_cycles - w0, 0);
    access(1'b0, 20'h00005, 2'b11, 16'h0, rd, err, lat, cc);
    chk(rd == 16'hA5A5 && !err, "R7", "read under low supply", rd, 16'hA5A5);
    plow = 1'b0;
  endtask

  task automatic t_brownout;
    int early = 0;
    @(negedge clk);
    rv = 1'b1; rwe = 1'b0; raddr = 20'h5; rbe = 2'b11;
    @(negedge clk);
    rv = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pg = 1'b0;
    #1;
    chk(rdy == 1'b0, "R2", "ready on drop", rdy, 0);
    @(negedge clk);
    chk({ce_n, oe_n, we_n} == 3'b111, "R2", "strobes after drop", {ce_n, oe_n, we_n}, 3'b111);
    chk(rspv && rspe, "R2", "abort rsp", {rspv, rspe}, 2'b11);
    repeat (3) @(negedge clk);
    pg = 1'b1;
    for (int k = 1; k < STARTUP; k++) begin
      @(negedge clk);
      if (rdy || !ce_n) early++;
    end
    chk(early == 0, "R2", "relock after brownout", early, 0);
    @(negedge clk);
    chk(rdy == 1'b1, "R2", "reopen after brownout", rdy, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startup();
    t_word();
    t_bytes();
    t_noop();
    t_inhibit();
    t_brownout();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule